// File: doc/BRIEF.md
# Two-Stage Pipelined Delta-Sigma Noise-Cancellation Combiner

This block takes the two single-bit streams of a 2+2 cascaded fourth-order delta-sigma modulator and merges them into one small signed word per modulator sample. The merged word goes to a decimation filter. Each new pair of bits arrives with a one-cycle sample strobe. The modulator runs at a quarter of the master clock, so the strobe normally pulses once every four master clocks.

Each bit is first mapped to a bipolar value. The block keeps a short history of each stream. It then forms a fixed weighted sum, built so that the second-stage bits cancel the quantization error of the first stage: three delayed first-stage taps weighted 3, −6 and 4, plus nine times the second difference of the second stage.

The stream is push-only. The input side has a valid strobe and no ready. The output side has a valid pulse and no ready, so the block applies no back-pressure, and the downstream filter must take every word in the cycle its valid is high.

Top module: `mash_combiner`

## Requirements
- R1: Each input bit is mapped to a bipolar value before weighting: a 1 counts as +1 and a 0 counts as −1.
- R2: With M0[n] and M1[n] the bits taken on the newest strobe and M0[n−k] the bit taken k strobes earlier, the output word equals 3·M0[n−2] − 6·M0[n−3] + 4·M0[n−4] + 9·(M1[n] − 2·M1[n−1] + M1[n−2]).
- R3: `out_valid` is high for exactly the one master clock that follows a clock in which `smp_valid` was high and the history was full. It is low at all other times.
- R4: `out_data` changes only in the clock after a strobe. Between strobes it holds its last value.
- R5: A synchronous reset clears all history to a zero value and drives `out_valid` and `out_data` to 0. The first four strobes after reset produce no valid output, and the fifth strobe produces the first valid word.
- R6: `out_data` is a 7-bit two's-complement word, and every valid output lies in the range −49 to +49.
- R7: Values on `m0_bit` and `m1_bit` in clocks where `smp_valid` is low are ignored. They change neither the output nor any later result.
- R8: A reset asserted in the middle of a stream restarts the four-sample fill, so again no valid word appears until the fifth strobe after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe: the modulator bits are valid in this clock |
| m0_bit | input | 1 | First-stage modulator bit |
| m1_bit | input | 1 | Second-stage modulator bit |
| out_valid | output | 1 | One-clock pulse marking a new combined word |
| out_data | output | 7 | Combined word, two's complement |

## Verification
After the fill phase, the bench drives every one of the 64 combinations of the six bits that carry weight: three first-stage taps and three second-stage taps. Each combination checks the output against the closed-form sum. This separates a wrong sign, a wrong weight, a swapped delay tap, and a wrong bipolar mapping. Between strobes the bench drives the inverse of the last bits on the data pins, which exposes any capture outside the strobe. A reset in mid-stream, followed by counting strobes up to the first valid word, separates a correct fill restart from a stale fill count.

// File: rtl/mash_pkg.sv
package mash_pkg;
  // Bipolar sample: -1, 0 (reset/empty) or +1
  typedef logic signed [1:0] bip_t;

  function automatic bip_t to_bip(input logic b);
    return b ? 2'sd1 : -2'sd1;
  endfunction
endpackage

// File: rtl/mash_tap_line.sv
module mash_tap_line #(
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  mash_pkg::bip_t                din,
  output mash_pkg::bip_t [DEPTH-1:0]    taps   // taps[k] = sample n-(k+1)
);
  mash_pkg::bip_t [DEPTH-1:0] hist_q;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          hist_q[k] <= '0;
        end else if (en) begin
          if (k == 0) hist_q[k] <= din;
          else        hist_q[k] <= hist_q[(k == 0) ? 0 : k-1];
        end
      end
    end
  endgenerate

  assign taps = hist_q;

  // R2: the newest stage captures the mapped input on a strobe
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> (taps[0] == $past(din)));

  // R7: history moves only on a strobe
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(taps));
endmodule

// File: rtl/mash_weight_sum.sv
module mash_weight_sum #(
  parameter int SUM_W = 8
) (
  input  mash_pkg::bip_t              m1_now,
  input  mash_pkg::bip_t [3:0]        m0_taps,  // n-1 .. n-4
  input  mash_pkg::bip_t [1:0]        m1_taps,  // n-1 .. n-2
  output logic signed [SUM_W-1:0]     sum
);
  logic signed [SUM_W-1:0] a2, a3, a4, b0, b1, b2, first, diff2, second;

  function automatic logic signed [SUM_W-1:0] ext(input mash_pkg::bip_t v);
    return {{(SUM_W-2){v[1]}}, v};
  endfunction

  always_comb begin
    a2 = ext(m0_taps[1]);
    a3 = ext(m0_taps[2]);
    a4 = ext(m0_taps[3]);
    b0 = ext(m1_now);
    b1 = ext(m1_taps[0]);
    b2 = ext(m1_taps[1]);
    // 3*a2 - 6*a3 + 4*a4
    first  = (a2 <<< 1) + a2 - (a3 <<< 2) - (a3 <<< 1) + (a4 <<< 2);
    // second difference, then *9
    diff2  = b0 - (b1 <<< 1) + b2;
    second = (diff2 <<< 3) + diff2;
    sum    = first + second;
  end
endmodule

// File: rtl/mash_combiner.sv
module mash_combiner #(
  parameter int OUT_W    = 7,
  parameter int M0_DEPTH = 4,
  parameter int M1_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic              m0_bit,
  input  logic              m1_bit,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  localparam int SUM_W = OUT_W + 1;
  localparam int CNT_W = $clog2(M0_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(M0_DEPTH);

  mash_pkg::bip_t                 m0_in, m1_in;
  mash_pkg::bip_t [M0_DEPTH-1:0]  m0_taps;
  mash_pkg::bip_t [M1_DEPTH-1:0]  m1_taps;
  logic signed [SUM_W-1:0]        sum;
  logic [CNT_W-1:0]               fill_q;
  logic                           primed;

  assign m0_in  = mash_pkg::to_bip(m0_bit);
  assign m1_in  = mash_pkg::to_bip(m1_bit);
  assign primed = (fill_q == FULL);

  mash_tap_line #(.DEPTH(M0_DEPTH)) u_m0_line (
    .clk(clk), .rst(rst), .en(smp_valid), .din(m0_in), .taps(m0_taps));

  mash_tap_line #(.DEPTH(M1_DEPTH)) u_m1_line (
    .clk(clk), .rst(rst), .en(smp_valid), .din(m1_in), .taps(m1_taps));

  mash_weight_sum #(.SUM_W(SUM_W)) u_sum (
    .m1_now(m1_in), .m0_taps(m0_taps[3:0]), .m1_taps(m1_taps[1:0]), .sum(sum));

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= smp_valid && primed;
      if (smp_valid) begin
        out_data <= sum[OUT_W-1:0];
        if (!primed) fill_q <= fill_q + 1'b1;
      end
    end
  end

  // R3: a valid word always follows a strobe by one clock
  p_valid_after_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(smp_valid));

  // R4: output word holds when no strobe came in
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(smp_valid) |-> $stable(out_data));

  // R5: no valid word before the history is full
  p_fill_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(fill_q) == FULL));

  // R6: valid words stay within the reachable range
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_data) <= 49 && $signed(out_data) >= -49));

  // R6: the truncated word matches the wide sum
  p_sum_fits_r6: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> (sum <= SUM_W'(49) && sum >= -SUM_W'(49)));
endmodule

// File: tb/test_mash_combiner.sv
module test_mash_combiner;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic m0_bit = 1'b0;
  logic m1_bit = 1'b0;
  logic out_valid;
  logic [6:0] out_data;

  int tests = 0;
  int fails = 0;
  int h0 [0:4];
  int h1 [0:2];
  int nsmp;
  int last_exp;

  always #5 clk = ~clk;

  mash_combiner i_mash_combiner (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .m0_bit(m0_bit),
    .m1_bit(m1_bit), .out_valid(out_valid), .out_data(out_data));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bip(input logic b);
    return b ? 1 : -1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) h0[k] = 0;
    for (int k = 0; k < 3; k++) h1[k] = 0;
    nsmp = 0; last_exp = 0;
    chk("R5 valid low after reset", int'(out_valid), 0);
    chk("R5 data zero after reset", int'($signed(out_data)), 0);
  endtask

  // one strobe, four clocks apart, checking every phase
  task automatic push(input logic b0, input logic b1);
    int e;
    bit ev;
    @(negedge clk);
    smp_valid = 1'b1; m0_bit = b0; m1_bit = b1;
    for (int k = 4; k > 0; k--) h0[k] = h0[k-1];
    for (int k = 2; k > 0; k--) h1[k] = h1[k-1];
    h0[0] = bip(b0); h1[0] = bip(b1);   // R1 mapping
    nsmp++;
    ev = (nsmp >= 5);
    e  = 3*h0[2] - 6*h0[3] + 4*h0[4] + 9*(h1[0] - 2*h1[1] + h1[2]);
    @(negedge clk);
    smp_valid = 1'b0; m0_bit = ~b0; m1_bit = ~b1;  // R7 garbage
    chk(ev ? "R3 valid pulse" : "R5 no valid during fill", int'(out_valid), int'(ev));
    if (ev) begin
      last_exp = e;
      chk("R2 weighted sum", int'($signed(out_data)), e);
      chk("R6 range", int'($signed(out_data) <= 49 && $signed(out_data) >= -49), 1);
    end
    @(negedge clk);
    chk("R3 valid one clock only", int'(out_valid), 0);
    @(negedge clk);
    if (nsmp >= 5) chk("R4 R7 data held between strobes", int'($signed(out_data)), last_exp);
  endtask

  initial begin
    #2ms;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R5: fill phase
    for (int i = 0; i < 4; i++) push(1'b1, 1'b0);
    // exhaustive sweep over the six weighted bits
    for (int p = 0; p < 64; p++) begin
      logic [5:0] v;
      int want;
      v = 6'(p);
      push(v[0], 1'b0);   // n-4
      push(v[1], 1'b0);   // n-3
      push(v[2], v[3]);   // n-2
      push(1'b0, v[4]);   // n-1
      push(1'b0, v[5]);   // n
      want = 3*bip(v[2]) - 6*bip(v[1]) + 4*bip(v[0])
           + 9*(bip(v[5]) - 2*bip(v[4]) + bip(v[3]));
      chk("R1 R2 closed form", int'($signed(out_data)), want);
    end
    // R6 extremes
    push(1'b1, 1'b1); push(1'b0, 1'b0); push(1'b1, 1'b1); push(1'b0, 1'b0); push(1'b0, 1'b1);
    chk("R6 max +49", int'($signed(out_data)), 49);
    push(1'b0, 1'b0); push(1'b1, 1'b1); push(1'b0, 1'b0); push(1'b0, 1'b1); push(1'b0, 1'b0);
    chk("R6 min -49", int'($signed(out_data)), -49);
    // R8: reset mid-stream restarts the fill
    push(1'b1, 1'b0); push(1'b0, 1'b1);
    do_reset();
    for (int i = 0; i < 4; i++) push(1'(i), 1'(i+1));
    push(1'b1, 1'b1);
    chk("R8 first valid on fifth strobe after reset", int'(last_exp == (3*h0[2] - 6*h0[3] + 4*h0[4] + 9*(h1[0] - 2*h1[1] + h1[2]))), 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule